// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block owns the program counter of a small processor core. Each clock cycle with `valid_i` high it takes one 3-bit operation and updates the PC. The PC can step to the next address, load a target address, branch on the zero or negative condition flag, or call and return from subroutines. The condition flags and the target address come from logic outside the block. The block does not fetch, decode or compute flags.

Return addresses live in a small internal last-in first-out store. Its pointer always names the next free slot. A call writes the address after the current PC into that slot, advances the pointer, and then loads the target. A return moves the pointer back one slot, reads the address stored there, and loads it into the PC. A call made when the store is full is refused and raises a sticky overflow flag. A return made when the store is empty is refused and raises a sticky underflow flag. In both cases the PC and the store are left as they were.

Top module: `pcseq_top`

## Requirements
- R1: A synchronous active-low reset sets the PC to 0, clears both error flags and empties the return store, so a return issued straight after reset underflows.
- R2: Operation code 0 (step) sets the PC to PC+1, wrapping from all-ones to 0. Codes 6 and 7 leave the PC unchanged.
- R3: Operation code 1 (jump) loads `target_i` into the PC, and the old PC is discarded.
- R4: Operation code 2 loads `target_i` when the zero flag (`flags_i[2]`) is 1. Otherwise it sets the PC to PC+1. The other flag bits have no effect on it.
- R5: Operation code 3 loads `target_i` when the negative flag (`flags_i[3]`) is 1. Otherwise it sets the PC to PC+1. The overflow (`flags_i[1]`) and carry (`flags_i[0]`) bits have no effect on it.
- R6: Operation code 4 (call) saves PC+1 and loads `target_i`. Operation code 5 (return) loads the most recently saved address that has not yet been returned to, in last-in first-out order.
- R7: The return store holds DEPTH entries (default 8). A call while it is full sets `ovf_o`, which stays 1 until reset, and changes neither the PC nor the stored addresses.
- R8: A return while the store is empty sets `unf_o`, which stays 1 until reset, and leaves the PC unchanged.
- R9: While `valid_i` is low, the PC, the return store and both flags hold their values, whatever the operation code is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code (0 step, 1 jump, 2 branch on zero, 3 branch on negative, 4 call, 5 return, 6/7 hold) |
| target_i | input | ADDR_W | Target address for jump, branch and call |
| flags_i | input | 4 | Condition flags: [3] negative, [2] zero, [1] overflow, [0] carry |
| pc_o | output | ADDR_W | Current program counter |
| ovf_o | output | 1 | Sticky return-store overflow flag |
| unf_o | output | 1 | Sticky return-store underflow flag |

## Verification
Every result is registered once. The PC and both error flags reflect an operation just after the rising edge that samples it with `valid_i` high, so each result is due one cycle after the stimulus. The bench drives each operation on a falling edge and holds it for exactly one rising edge. It then drops `valid_i` and compares the outputs on the next falling edge, halfway between the update edge and the next one. The contents of the return store are observed only through the PC values that later returns produce, including a pop that follows a refused call.

// File: rtl/pcseq_pkg.sv
// Shared encodings for the program counter sequencer.
package pcseq_pkg;
    typedef enum logic [2:0] {
        OP_STEP  = 3'd0,
        OP_JUMP  = 3'd1,
        OP_BRZ   = 3'd2,
        OP_BRN   = 3'd3,
        OP_CALL  = 3'd4,
        OP_RET   = 3'd5,
        OP_HOLDA = 3'd6,
        OP_HOLDB = 3'd7
    } seq_op_e;

    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;
endpackage

// File: rtl/pcseq_ret_stack.sv
// Return-address LIFO. The pointer names the next free slot: a push writes
// there and then advances; a pop steps back and the slot below is presented.
// Assumes the caller never asks for push and pop in the same cycle and only
// pushes when not full and pops when not empty.
module pcseq_ret_stack #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] push_data_i,
    output logic [ADDR_W-1:0] top_o,
    output logic              full_o,
    output logic              empty_o
);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ADDR_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  ptr_dec;

    assign ptr_dec = ptr_q - PTR_W'(1);
    assign full_o  = (ptr_q == PTR_W'(DEPTH));
    assign empty_o = (ptr_q == '0);
    assign top_o   = slot_q[ptr_dec[IDX_W-1:0]];

    // Pointer: advance on push, step back on pop, empty on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (push_i && !full_o) begin
            ptr_q <= ptr_q + PTR_W'(1);
        end else if (pop_i && !empty_o) begin
            ptr_q <= ptr_dec;
        end
    end

    // Storage: write the pushed address into the free slot.
    always_ff @(posedge clk) begin
        if (push_i && !full_o) begin
            slot_q[ptr_q[IDX_W-1:0]] <= push_data_i;
        end
    end

    // R6
    stack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o) |=> $stable(ptr_q));

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o) |=> $stable(ptr_q));

    // R7
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_W'(DEPTH));
endmodule

// File: rtl/pcseq_next_pc.sv
// Next-PC selection. Purely combinational: from the operation, the current
// PC, the flags and the stack state it picks the next PC and raises the
// push, pop and error requests. Assumes the results are used only when an
// operation is valid.
module pcseq_next_pc
    import pcseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  seq_op_e           op_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              flag_n_i,
    input  logic              flag_z_i,
    input  logic              full_i,
    input  logic              empty_i,
    input  logic [ADDR_W-1:0] top_i,
    output logic [ADDR_W-1:0] pc_next_o,
    output logic [ADDR_W-1:0] pc_inc_o,
    output logic              push_o,
    output logic              pop_o,
    output logic              set_ovf_o,
    output logic              set_unf_o
);
    assign pc_inc_o = pc_i + ADDR_W'(1);

    // Decode the operation into a next PC and stack/error requests.
    always_comb begin
        pc_next_o = pc_i;
        push_o    = 1'b0;
        pop_o     = 1'b0;
        set_ovf_o = 1'b0;
        set_unf_o = 1'b0;
        case (op_i)
            OP_STEP: pc_next_o = pc_inc_o;
            OP_JUMP: pc_next_o = target_i;
            OP_BRZ:  pc_next_o = flag_z_i ? target_i : pc_inc_o;
            OP_BRN:  pc_next_o = flag_n_i ? target_i : pc_inc_o;
            OP_CALL: begin
                if (full_i) begin
                    set_ovf_o = 1'b1;
                end else begin
                    push_o    = 1'b1;
                    pc_next_o = target_i;
                end
            end
            OP_RET: begin
                if (empty_i) begin
                    set_unf_o = 1'b1;
                end else begin
                    pop_o     = 1'b1;
                    pc_next_o = top_i;
                end
            end
            default: pc_next_o = pc_i;
        endcase
    end
endmodule

// File: rtl/pcseq_top.sv
// Program counter sequencer top. Registers the PC and the sticky error
// flags and updates them once per valid operation. Assumes the target and
// flags are stable in the same cycle as valid_i.
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [2:0]        op_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [3:0]        flags_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              ovf_o,
    output logic              unf_o
);
    seq_op_e           op;
    logic [ADDR_W-1:0] pc_q;
    logic              ovf_q;
    logic              unf_q;
    logic [ADDR_W-1:0] pc_next;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] stk_top;
    logic              stk_full;
    logic              stk_empty;
    logic              push_req;
    logic              pop_req;
    logic              set_ovf;
    logic              set_unf;
    logic              flags_unused;

    assign op           = seq_op_e'(op_i);
    assign flags_unused = flags_i[FLG_V] ^ flags_i[FLG_C];

    pcseq_next_pc #(.ADDR_W(ADDR_W)) sel_i (
        .op_i      (op),
        .pc_i      (pc_q),
        .target_i  (target_i),
        .flag_n_i  (flags_i[FLG_N]),
        .flag_z_i  (flags_i[FLG_Z]),
        .full_i    (stk_full),
        .empty_i   (stk_empty),
        .top_i     (stk_top),
        .pc_next_o (pc_next),
        .pc_inc_o  (pc_inc),
        .push_o    (push_req),
        .pop_o     (pop_req),
        .set_ovf_o (set_ovf),
        .set_unf_o (set_unf)
    );

    pcseq_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) stk_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (valid_i && push_req),
        .pop_i       (valid_i && pop_req),
        .push_data_i (pc_inc),
        .top_o       (stk_top),
        .full_o      (stk_full),
        .empty_o     (stk_empty)
    );

    // PC and sticky flags: update only on a valid operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else if (valid_i) begin
            pc_q <= pc_next;
            if (set_ovf) ovf_q <= 1'b1;
            if (set_unf) unf_q <= 1'b1;
        end
    end

    assign pc_o  = pc_q;
    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(pc_q) && $stable(ovf_q) && $stable(unf_q)));

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd0) |=> pc_q == $past(pc_q) + ADDR_W'(1));

    // R3
    jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd1) |=> pc_q == $past(target_i));

    // R6
    call_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd4 && !stk_full) |=> pc_q == $past(target_i));

    // R7
    full_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd4 && stk_full) |=> (ovf_q && $stable(pc_q)));

    // R8
    empty_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd5 && stk_empty) |=> (unf_q && $stable(pc_q)));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R8
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |=> unf_q);
endmodule

// File: tb/pcseq_top_tb_top.sv
module pcseq_top_tb_top;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [AW-1:0] target = '0;
    logic [3:0]    flags = 4'd0;
    logic [AW-1:0] pc;
    logic          ovf;
    logic          unf;
    int            n_run = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    pcseq_top #(.ADDR_W(AW), .DEPTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid), .op_i(op),
        .target_i(target), .flags_i(flags), .pc_o(pc), .ovf_o(ovf), .unf_o(unf)
    );

    always #4 clk = ~clk;

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] o, input logic [AW-1:0] t, input logic [3:0] f);
        @(negedge clk);
        valid = 1'b1; op = o; target = t; flags = f;
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 pc", pc, 0);
        check("R1 ovf", ovf, 0);
        check("R1 unf", unf, 0);
    endtask

    task automatic t_step();
        do_reset();
        for (int i = 0; i < 3; i++) issue(3'd0, 16'h0BAD, 4'hF);
        check("R2 step", pc, 3);
        issue(3'd6, 16'h0BAD, 4'hF);
        check("R2 op6 hold", pc, 3);
        issue(3'd7, 16'h0BAD, 4'hF);
        check("R2 op7 hold", pc, 3);
        issue(3'd1, 16'hFFFF, 4'h0);
        issue(3'd0, 16'h0000, 4'h0);
        check("R2 wrap", pc, 0);
    endtask

    task automatic t_idle();
        do_reset();
        issue(3'd1, 16'h0040, 4'h0);
        check("R3 jump", pc, 16'h0040);
        @(negedge clk);
        valid = 1'b0; op = 3'd1; target = 16'h0555;
        @(negedge clk);
        @(negedge clk);
        check("R9 idle jump", pc, 16'h0040);
        op = 3'd4; target = 16'h0777;
        @(negedge clk);
        @(negedge clk);
        check("R9 idle call pc", pc, 16'h0040);
        issue(3'd5, 16'h0000, 4'h0);
        check("R9 idle call no push", unf, 1);
        check("R9 ret pc kept", pc, 16'h0040);
    endtask

    task automatic t_branch();
        do_reset();
        issue(3'd1, 16'h0200, 4'h0);
        issue(3'd2, 16'h0300, 4'b0100);
        check("R4 bz taken", pc, 16'h0300);
        issue(3'd2, 16'h0900, 4'b1011);
        check("R4 bz not taken", pc, 16'h0301);
        issue(3'd3, 16'h0400, 4'b1000);
        check("R5 bn taken", pc, 16'h0400);
        issue(3'd3, 16'h0900, 4'b0111);
        check("R5 bn not taken", pc, 16'h0401);
    endtask

    task automatic t_call();
        do_reset();
        issue(3'd1, 16'h0050, 4'h0);
        issue(3'd4, 16'h1000, 4'h0);
        check("R6 call", pc, 16'h1000);
        issue(3'd0, 16'h0000, 4'h0);
        issue(3'd4, 16'h2000, 4'h0);
        check("R6 nested call", pc, 16'h2000);
        issue(3'd5, 16'h0000, 4'h0);
        check("R6 ret inner", pc, 16'h1002);
        issue(3'd5, 16'h0000, 4'h0);
        check("R6 ret outer", pc, 16'h0051);
        check("R6 no ovf", ovf, 0);
        check("R6 no unf", unf, 0);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int k = 0; k < 8; k++) issue(3'd4, AW'(16'h10 * (k + 1)), 4'h0);
        check("R7 full pc", pc, 16'h0080);
        check("R7 ovf clear", ovf, 0);
        issue(3'd4, 16'h0999, 4'h0);
        check("R7 refused pc", pc, 16'h0080);
        check("R7 ovf set", ovf, 1);
        for (int k = 7; k >= 0; k--) begin
            issue(3'd5, 16'h0000, 4'h0);
            check("R7 stack intact", pc, 16'h10 * k + 1);
        end
        check("R7 ovf sticky", ovf, 1);
        check("R7 no unf", unf, 0);
    endtask

    task automatic t_underflow();
        do_reset();
        issue(3'd5, 16'h0333, 4'h0);
        check("R8 unf pc", pc, 0);
        check("R8 unf set", unf, 1);
        check("R8 ovf clear", ovf, 0);
        issue(3'd0, 16'h0000, 4'h0);
        check("R8 unf sticky", unf, 1);
        check("R8 step after", pc, 1);
        do_reset();
        check("R1 unf cleared", unf, 0);
    endtask

    initial begin
        t_reset();
        t_step();
        t_idle();
        t_branch();
        t_call();
        t_overflow();
        t_underflow();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule